// File: doc/BRIEF.md
# Eight-Bit Arithmetic/Logic Unit with Flag Generation

The block is a purely combinational 8-bit datapath for a small microcontroller core. It takes two operands (`a_i`, `b_i`), a 4-bit operation code, and the current carry and half-carry flags. From these it produces an 8-bit result, the new values of four condition flags, and a mask that shows which flags the operation may change. The status register outside the block uses the mask to merge the new flags into its stored state. The status register also holds the stored state itself.

The block covers binary addition and subtraction, both with and without an incoming carry. It also covers decimal correction after a BCD addition, the bitwise logic operations, one's complement, plain rotates, rotates through carry, and increment and decrement. Subtraction is built as addition of the inverted subtrahend, so the carry and half-carry flags report "no borrow". Signed overflow comes from comparing the carry into the top bit with the carry out of it. Flags are packed as `{OV, Z, AC, C}`, with C in bit 0, in both `flags_o` and `upd_o`.

Top module: `alu8_core`

## Requirements
- R1: The operation codes are ADD=0, ADC=1, SUB=2, SBC=3, DAA=4, AND=5, OR=6, XOR=7, CPL=8, RL=9, RR=10, RLC=11, RRC=12, INC=13, DEC=14 and 15=pass. ADD gives a+b. ADC gives a+b+c_i. SUB gives a+~b+1. SBC gives a+~b+c_i. The result is taken modulo 256, and ADD and SUB ignore c_i.
- R2: For ADD, ADC, SUB and SBC, the C flag (flags_o bit 0) is the carry out of bit 7. For a subtraction this equals 1 when no borrow occurs.
- R3: For ADD, ADC, SUB and SBC, the AC flag (flags_o bit 1) is the carry out of bit 3. For a subtraction this equals 1 when no borrow crosses the nibble boundary.
- R4: For ADD, ADC, SUB and SBC, the OV flag (flags_o bit 3) is 1 exactly when the carry into bit 7 differs from the carry out of bit 7.
- R5: Whenever the Z mask bit is set, the Z flag (flags_o bit 2) is 1 if the 8-bit result is 0x00, and 0 otherwise.
- R6: RL and RR rotate a_i left or right by one bit within 8 bits. RLC moves c_i into bit 0 and old bit 7 into C. RRC moves c_i into bit 7 and old bit 0 into C.
- R7: DAA first adds 0x06 if the low nibble of a_i exceeds 9 or ac_i is 1. It then adds 0x60 if that sum carried out of bit 7, if its high nibble exceeds 9, or if c_i is 1. C becomes 1 whenever the 0x60 step applies, and DAA never returns C=0 while c_i=1.
- R8: AND, OR and XOR combine a_i with b_i bitwise. CPL returns ~a_i. INC returns a_i+1 and DEC returns a_i-1, both modulo 256. c_i and ac_i have no effect on these results.
- R9: upd_o is 4'b1111 for ADD/ADC/SUB/SBC, 4'b0101 for DAA, 4'b0100 for AND/OR/XOR/CPL/INC/DEC, 4'b0001 for RLC/RRC, and 4'b0000 for RL/RR/code 15. Code 15 returns a_i unchanged. Every flags_o bit whose mask bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 4 | Operation select |
| a_i | input | 8 | First operand; the only operand of unary operations |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current half-carry flag |
| result_o | output | 8 | Operation result |
| flags_o | output | 4 | New flag values {OV, Z, AC, C}, zero outside the mask |
| upd_o | output | 4 | Flags that the operation may change, same bit order |

## Verification
The bench aims at the carry boundaries. These are 0xFF+0x01, equal-operand subtraction that yields zero with C=1, and a subtract that borrows. A design that fails to invert the borrow sense would report C and AC backwards here. Signed overflow is driven in both directions, 0x3A+0x47 and 0x80-0x01, to expose an overflow taken from the wrong carry pair. The DAA cases include 0xFA, whose low-nibble fix-up carries out of bit 7; a design that only compares the high nibble with 9 would return 0x00 instead of 0x60. Further cases show that an incoming C survives DAA, that ADD ignores c_i, and that a zero result from RL keeps Z at 0, because Z lies outside RL's mask.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W  = 8;
  localparam int NIB_W   = 4;
  localparam int NIB_CNT = DATA_W / NIB_W;
  localparam int OP_W    = 4;
  localparam int FLG_W   = 4;

  // flag bit positions, shared by the new-flag and mask vectors
  localparam int FC  = 0;
  localparam int FAC = 1;
  localparam int FZ  = 2;
  localparam int FOV = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_DAA = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_CPL = 4'd8,
    OP_RL  = 4'd9,
    OP_RR  = 4'd10,
    OP_RLC = 4'd11,
    OP_RRC = 4'd12,
    OP_INC = 4'd13,
    OP_DEC = 4'd14,
    OP_PAS = 4'd15
  } alu_op_e;

  // R9: which flags each operation may change
  function automatic logic [FLG_W-1:0] op_mask(alu_op_e op);
    logic [FLG_W-1:0] m;
    m = '0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: m = '1;
      OP_DAA: begin
        m[FC] = 1'b1;
        m[FZ] = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_CPL, OP_INC, OP_DEC: m[FZ] = 1'b1;
      OP_RLC, OP_RRC: m[FC] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int NW  = NIB_W
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           c_in,
  input  logic           ac_in,
  output logic [W-1:0]   sum,
  output logic           c_out,
  output logic           ac_out,
  output logic           ov_out
);

  localparam int NC = W / NW;
  localparam logic [NW-1:0] DEC_MAX = NW'(9);
  localparam logic [W:0]    LO_ADJ  = (W+1)'(6);
  localparam logic [W-1:0]  HI_ADJ  = W'(6) << NW;

  logic          is_sub;
  logic          cin;
  logic [W-1:0]  bx;
  logic [W-1:0]  bin_sum;
  logic [NC:0]   cy;
  logic          c_into_msb;

  // operand conditioning: subtraction = add inverted subtrahend
  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_SBC);
    bx     = is_sub ? ~b : b;
    case (op)
      OP_ADD:  cin = 1'b0;
      OP_SUB:  cin = 1'b1;
      default: cin = c_in;
    endcase
  end

  // nibble-wide ripple chain; cy[1] is the half carry
  assign cy[0] = cin;
  for (genvar g = 0; g < NC; g++) begin : g_nib
    logic [NW:0] s;
    assign s = {1'b0, a[g*NW +: NW]} + {1'b0, bx[g*NW +: NW]}
             + {{NW{1'b0}}, cy[g]};
    assign bin_sum[g*NW +: NW] = s[NW-1:0];
    assign cy[g+1] = s[NW];
  end

  // carry into the top bit recovered from the sum bit
  assign c_into_msb = bin_sum[W-1] ^ a[W-1] ^ bx[W-1];

  // decimal adjust path
  logic          lo_fix;
  logic          hi_fix;
  logic [W:0]    t_lo;
  logic [W-1:0]  daa_res;

  always_comb begin
    lo_fix  = (a[NW-1:0] > DEC_MAX) || ac_in;
    t_lo    = {1'b0, a} + (lo_fix ? LO_ADJ : '0);
    hi_fix  = t_lo[W] || (t_lo[W-1 -: NW] > DEC_MAX) || c_in;
    daa_res = t_lo[W-1:0] + (hi_fix ? HI_ADJ : '0);
  end

  always_comb begin
    if (op == OP_DAA) begin
      sum    = daa_res;
      c_out  = hi_fix;
      ac_out = 1'b0;
      ov_out = 1'b0;
    end else begin
      sum    = bin_sum;
      c_out  = cy[NC];
      ac_out = cy[1];
      ov_out = c_into_msb ^ cy[NC];
    end
  end

  // R2
  always_comb begin
    if (op == OP_ADD && !$isunknown({a, b}))
      add_carry_chk: assert ({c_out, sum} == ({1'b0, a} + {1'b0, b}))
        else $error("addsub: ADD carry/sum mismatch");
  end

  // R4
  always_comb begin
    if ((op == OP_ADD || op == OP_SUB) && !$isunknown({a, b, sum}))
      signed_ovf_chk: assert (ov_out ==
          (((op == OP_ADD) ? (a[W-1] == b[W-1]) : (a[W-1] != b[W-1]))
           && (sum[W-1] != a[W-1])))
        else $error("addsub: overflow flag disagrees with sign rule");
  end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  alu_op_e       op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          c_in,
  output logic [W-1:0]  res,
  output logic          c_out
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    res   = a;
    c_out = c_in;
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_CPL: res = ~a;
      OP_RL:  res = {a[W-2:0], a[W-1]};
      OP_RR:  res = {a[0], a[W-1:1]};
      OP_RLC: begin
        res   = {a[W-2:0], c_in};
        c_out = a[W-1];
      end
      OP_RRC: begin
        res   = {c_in, a[W-1:1]};
        c_out = a[0];
      end
      OP_INC: res = a + ONE;
      OP_DEC: res = a - ONE;
      default: res = a;
    endcase
  end

  // R6
  always_comb begin
    if ((op == OP_RLC || op == OP_RRC) && !$isunknown({a, c_in}))
      rot_carry_chk: assert ($countones({c_out, res}) == $countones({a, c_in}))
        else $error("bitops: rotate through carry lost or gained a bit");
    if ((op == OP_RL || op == OP_RR) && !$isunknown(a))
      rot_plain_chk: assert ($countones(res) == $countones(a))
        else $error("bitops: plain rotate lost or gained a bit");
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c_i,
  input  logic              ac_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLG_W-1:0]  flags_o,
  output logic [FLG_W-1:0]  upd_o
);

  alu_op_e           op;
  logic [DATA_W-1:0] as_sum;
  logic              as_c;
  logic              as_ac;
  logic              as_ov;
  logic [DATA_W-1:0] bo_res;
  logic              bo_c;
  logic              arith_sel;
  logic [FLG_W-1:0]  raw_flags;
  logic [FLG_W-1:0]  mask;

  assign op = alu_op_e'(opcode_i);

  alu8_addsub #(.W(DATA_W), .NW(NIB_W)) u_addsub (
    .op     (op),
    .a      (a_i),
    .b      (b_i),
    .c_in   (c_i),
    .ac_in  (ac_i),
    .sum    (as_sum),
    .c_out  (as_c),
    .ac_out (as_ac),
    .ov_out (as_ov)
  );

  alu8_bitops #(.W(DATA_W)) u_bitops (
    .op    (op),
    .a     (a_i),
    .b     (b_i),
    .c_in  (c_i),
    .res   (bo_res),
    .c_out (bo_c)
  );

  always_comb begin
    arith_sel = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB)
             || (op == OP_SBC) || (op == OP_DAA);
    result_o  = arith_sel ? as_sum : bo_res;
    mask      = op_mask(op);
    raw_flags[FC]  = arith_sel ? as_c : bo_c;
    raw_flags[FAC] = as_ac;
    raw_flags[FZ]  = (result_o == '0);
    raw_flags[FOV] = as_ov;
    flags_o   = raw_flags & mask;
    upd_o     = mask;
  end

  // R7
  always_comb begin
    if (op == OP_DAA && c_i === 1'b1)
      daa_keeps_c_chk: assert (flags_o[FC] && upd_o[FC])
        else $error("core: DAA cleared an incoming carry");
  end

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

  logic       clk;
  logic [3:0] opcode_i;
  logic [7:0] a_i;
  logic [7:0] b_i;
  logic       c_i;
  logic       ac_i;
  logic [7:0] result_o;
  logic [3:0] flags_o;
  logic [3:0] upd_o;

  int checks;
  int errors;
  bit done;

  alu8_core dut (
    .opcode_i (opcode_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .c_i      (c_i),
    .ac_i     (ac_i),
    .result_o (result_o),
    .flags_o  (flags_o),
    .upd_o    (upd_o)
  );

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: {op, a, b, c, ac, result, flags{OV,Z,AC,C}, mask}
  localparam int NV = 26;
  localparam logic [37:0] VEC [NV] = '{
    {4'd0,  8'h3A, 8'h47, 1'b0, 1'b0, 8'h81, 4'b1010, 4'hF}, // R1 R3 R4 add, ovf
    {4'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 4'b0111, 4'hF}, // R2 R5 wrap
    {4'd1,  8'h10, 8'h20, 1'b1, 1'b0, 8'h31, 4'b0000, 4'hF}, // R1 adc
    {4'd2,  8'h50, 8'h30, 1'b0, 1'b0, 8'h20, 4'b0011, 4'hF}, // R2 no borrow
    {4'd2,  8'h30, 8'h50, 1'b0, 1'b0, 8'hE0, 4'b0010, 4'hF}, // R2 borrow
    {4'd3,  8'h80, 8'h01, 1'b1, 1'b0, 8'h7F, 4'b1001, 4'hF}, // R4 sbc ovf
    {4'd3,  8'h05, 8'h05, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'hF}, // R3 sbc borrow
    {4'd2,  8'h42, 8'h42, 1'b0, 1'b0, 8'h00, 4'b0111, 4'hF}, // R5 sub zero
    {4'd4,  8'h0F, 8'h00, 1'b0, 1'b0, 8'h15, 4'b0000, 4'h5}, // R7 low fix
    {4'd4,  8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0101, 4'h5}, // R7 both fix
    {4'd4,  8'h23, 8'h00, 1'b0, 1'b1, 8'h29, 4'b0000, 4'h5}, // R7 ac forced
    {4'd4,  8'h23, 8'h00, 1'b1, 1'b0, 8'h83, 4'b0001, 4'h5}, // R7 c kept
    {4'd4,  8'hFA, 8'h00, 1'b0, 1'b0, 8'h60, 4'b0001, 4'h5}, // R7 carry from low fix
    {4'd5,  8'hF0, 8'h0F, 1'b1, 1'b1, 8'h00, 4'b0100, 4'h4}, // R8 and
    {4'd6,  8'hA0, 8'h05, 1'b0, 1'b0, 8'hA5, 4'b0000, 4'h4}, // R8 or
    {4'd7,  8'h5A, 8'h5A, 1'b0, 1'b0, 8'h00, 4'b0100, 4'h4}, // R8 xor
    {4'd8,  8'hFF, 8'h12, 1'b0, 1'b0, 8'h00, 4'b0100, 4'h4}, // R8 cpl
    {4'd9,  8'h81, 8'h00, 1'b1, 1'b0, 8'h03, 4'b0000, 4'h0}, // R6 rl
    {4'd10, 8'h01, 8'h00, 1'b0, 1'b0, 8'h80, 4'b0000, 4'h0}, // R6 rr
    {4'd11, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0001, 4'h1}, // R6 rlc
    {4'd12, 8'h02, 8'h00, 1'b1, 1'b0, 8'h81, 4'b0000, 4'h1}, // R6 rrc
    {4'd13, 8'hFF, 8'h00, 1'b1, 1'b1, 8'h00, 4'b0100, 4'h4}, // R8 inc wrap
    {4'd14, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'h4}, // R8 dec wrap
    {4'd15, 8'h6C, 8'h33, 1'b1, 1'b1, 8'h6C, 4'b0000, 4'h0}, // R9 pass
    {4'd0,  8'h01, 8'h01, 1'b1, 1'b0, 8'h02, 4'b0000, 4'hF}, // R1 add ignores c
    {4'd9,  8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0000, 4'h0}  // R9 z masked
  };

  function automatic string req_of(logic [3:0] op);
    if (op <= 4'd3) return "R1";
    if (op == 4'd4) return "R7";
    if (op >= 4'd9 && op <= 4'd12) return "R6";
    if (op == 4'd15) return "R9";
    return "R8";
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] op, logic [7:0] a, logic [7:0] b,
                       logic c, logic ac);
    @(negedge clk);
    opcode_i = op;
    a_i      = a;
    b_i      = b;
    c_i      = c;
    ac_i     = ac;
    #1;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    opcode_i = 4'd0;
    a_i = 8'h00;
    b_i = 8'h00;
    c_i = 1'b0;
    ac_i = 1'b0;
    repeat (2) @(posedge clk);

    // idle state: all-zero inputs select ADD of zeros
    apply(4'd0, 8'h00, 8'h00, 1'b0, 1'b0);
    chk("R1", "idle result", result_o, 8'h00);
    chk("R5", "idle flags", {4'h0, flags_o}, 8'h04);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      apply(v[37:34], v[33:26], v[25:18], v[17], v[16]);
      chk(req_of(v[37:34]), "result", result_o, v[15:8]);
      chk("R2 R3 R4 R5", "flags", {4'h0, flags_o}, {4'h0, v[7:4]});
      chk("R9", "mask", {4'h0, upd_o}, {4'h0, v[3:0]});
    end

    // directed: DAA holds an incoming carry for every nibble pattern
    for (int x = 0; x < 16; x++) begin
      apply(4'd4, {x[3:0], 4'h1}, 8'h00, 1'b1, 1'b0);
      chk("R7", "daa c held", {7'h0, flags_o[0]}, 8'h01);
    end

    // directed: SUB full-range carry = no-borrow, against a bench model
    for (int x = 0; x < 8; x++) begin
      logic [7:0] aa;
      logic [7:0] bb;
      aa = 8'(x * 37);
      bb = 8'(x * 53 + 11);
      apply(4'd2, aa, bb, 1'b0, 1'b0);
      chk("R2", "sub carry", {7'h0, flags_o[0]}, {7'h0, aa >= bb});
      chk("R3", "sub half", {7'h0, flags_o[1]}, {7'h0, aa[3:0] >= bb[3:0]});
      chk("R1", "sub result", result_o, aa - bb);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule